// File: doc/BRIEF.md
# Cascaded Prescaled Timer Bank

The block holds eight programmable down-counting timers that share one clock. Two of them count system clock cycles directly. The first of these is a prescaler. Its single-cycle tick is the only event that advances the six secondary timers. The second system-clock divider produces a single-cycle enable that an SPI host uses to pace its bit clock.

Of the six secondary timers, the first three reload themselves and run without pause. The last three fire once and then wait until software rewrites their divisor. An expiry of any secondary timer sets a sticky pending bit. The interrupt request is raised when any pending bit is set whose enable bit is also set.

Software reaches the bank through a simple write-strobe register port with a combinational read path. The port covers the divisors, the pending flags and the interrupt enables.

Top module: `timer_bank`

## Requirements
- R1: A divisor N written to address 0 loads the prescaler counter. `pre_tick` is then high for one cycle, N cycles after the write edge, and again every N+1 cycles after that.
- R2: A divisor N written to address 1 behaves the same way for the SPI divider, whose tick is `spi_clk_en`. It runs independently of the prescaler.
- R3: Secondary timer j (0 to 5) is written at address 2+j. A write of S loads its counter, and the timer counts only in cycles where `pre_tick` is high. Its first expiry, `sec_tick[j]`, coincides with the (S+1)-th prescaler tick counted from the write cycle.
- R4: Secondary timers 0, 1 and 2 reload on expiry and fire again every S+1 prescaler ticks.
- R5: Secondary timers 3, 4 and 5 are one-shot: they fire once and stay silent until their divisor is written again, and that write re-arms them.
- R6: While reset is high, every tick output and `irq` is low. Reset leaves every divisor, every pending bit and every enable at zero, with every one-shot timer disarmed.
- R7: An expiry of secondary timer j sets bit j of the pending register at address 8. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: When an expiry of timer j and a write of 1 to pending bit j fall in the same cycle, the bit remains set.
- R9: `irq` is high exactly when some pending bit j is set together with bit j of the enable register at address 9.
- R10: Reading addresses 0 to 7 returns the divisor last written there. Reading address 8 returns the pending bits, address 9 returns the enables, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pre_tick | output | 1 | Prescaler tick |
| spi_clk_en | output | 1 | SPI bit-clock enable tick |
| sec_tick | output | 6 | Expiry pulses of the secondary timers |
| irq | output | 1 | Interrupt request |

## Verification
A timer can expire in the same cycle that software writes 1 to that timer's pending bit. The outcome of this collision decides whether an interrupt is lost. The bench arms a one-shot timer and computes the cycle of its expiry from the prescaler phase. It then presents the clear write in exactly that cycle, and the bit must read back as set. A clear issued afterwards must read back as cleared. Tick timing is judged by a scoreboard that predicts each tick cycle from the divisors and the write cycles.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int CW = 16,
  parameter int NC = 3,
  parameter int NO = 3,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   rdata,
  output logic            pre_tick,
  output logic            spi_clk_en,
  output logic [NC+NO-1:0] sec_tick,
  output logic            irq
);
  localparam int NS = NC + NO;
  localparam logic [AW-1:0] A_PRE  = AW'(0);
  localparam logic [AW-1:0] A_SPI  = AW'(1);
  localparam logic [AW-1:0] A_PEND = AW'(2 + NS);
  localparam logic [AW-1:0] A_IEN  = AW'(3 + NS);

  logic [CW-1:0] pre_div, pre_cnt, spi_div, spi_cnt;
  logic [CW-1:0] sdiv [NS];
  logic [CW-1:0] scnt [NS];
  logic [NS-1:0] run, pend, ien, clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_div <= '0;
      pre_cnt <= '0;
    end else if (wr_en && addr == A_PRE) begin
      pre_div <= wdata;
      pre_cnt <= wdata;
    end else begin
      pre_cnt <= (pre_cnt == '0) ? pre_div : pre_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_div <= '0;
      spi_cnt <= '0;
    end else if (wr_en && addr == A_SPI) begin
      spi_div <= wdata;
      spi_cnt <= wdata;
    end else begin
      spi_cnt <= (spi_cnt == '0) ? spi_div : spi_cnt - 1'b1;
    end
  end

  assign pre_tick   = !rst && pre_cnt == '0;
  assign spi_clk_en = !rst && spi_cnt == '0;

  for (genvar j = 0; j < NS; j++) begin : g_sec
    localparam logic [AW-1:0] MY_A = AW'(2 + j);
    logic hit;
    assign hit = wr_en && addr == MY_A;
    assign sec_tick[j] = pre_tick && run[j] && scnt[j] == '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        sdiv[j] <= '0;
        scnt[j] <= '0;
      end else if (hit) begin
        sdiv[j] <= wdata;
        scnt[j] <= wdata;
      end else if (pre_tick && run[j]) begin
        scnt[j] <= (scnt[j] == '0) ? sdiv[j] : scnt[j] - 1'b1;
      end
    end

    if (j < NC) begin : g_cont
      assign run[j] = 1'b1;
    end else begin : g_once
      always_ff @(posedge clk) begin
        if (rst)              run[j] <= 1'b0;
        else if (hit)         run[j] <= 1'b1;
        else if (sec_tick[j]) run[j] <= 1'b0;
      end
    end
  end

  assign clr = (wr_en && addr == A_PEND) ? wdata[NS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      ien  <= '0;
    end else begin
      pend <= (pend & ~clr) | sec_tick;
      if (wr_en && addr == A_IEN) ien <= wdata[NS-1:0];
    end
  end

  assign irq = |(pend & ien);

  always_comb begin
    rdata = '0;
    if (addr == A_PRE)  rdata = pre_div;
    if (addr == A_SPI)  rdata = spi_div;
    if (addr == A_PEND) rdata = CW'(pend);
    if (addr == A_IEN)  rdata = CW'(ien);
    for (int j = 0; j < NS; j++)
      if (addr == AW'(2 + j)) rdata = sdiv[j];
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int CW = 16,
  parameter int NC = 3,
  parameter int NO = 3,
  parameter int AW = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [CW-1:0]      wdata,
  input logic               pre_tick,
  input logic [NC+NO-1:0]   sec_tick,
  input logic [NC+NO-1:0]   run,
  input logic [NC+NO-1:0]   pend,
  input logic               irq
);
  localparam int NS = NC + NO;
  localparam logic [AW-1:0] A_PEND = AW'(2 + NS);
  localparam logic [AW-1:0] A_IEN  = AW'(3 + NS);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  p_sec_on_pre_r3: assert property (@(posedge clk) disable iff (rst)
    (|sec_tick) |-> pre_tick);

  p_reset_disarm_r6: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> run[NS-1:NC] == '0);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((|sec_tick) || (wr_en && addr == A_IEN)));

  for (genvar j = 0; j < NS; j++) begin : g_chk
    p_pend_set_r8: assert property (@(posedge clk) disable iff (rst)
      sec_tick[j] |=> pend[j]);

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_PEND && wdata[j] && !sec_tick[j]) |=> !pend[j]);

    if (j >= NC) begin : g_once
      p_once_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (sec_tick[j] && !(wr_en && addr == AW'(2 + j))) |=> !run[j]);
    end
  end
endmodule

bind timer_bank timer_bank_chk #(.CW(CW), .NC(NC), .NO(NO), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pre_tick(pre_tick), .sec_tick(sec_tick), .run(run), .pend(pend), .irq(irq)
);

// File: tb/timer_bank_test.sv
module timer_bank_test;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic pre_tick, spi_clk_en, irq;
  logic [5:0] sec_tick;

  timer_bank uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pre_tick(pre_tick), .spi_clk_en(spi_clk_en),
    .sec_tick(sec_tick), .irq(irq));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  int kp = -1, ks = -1, pdiv = 0, sdv = 0;
  int kj[6] = '{-1, -1, -1, -1, -1, -1};
  int dj[6] = '{0, 0, 0, 0, 0, 0};

  int exp_q[$];
  bit won = 0;
  int wsel = 0;
  string wreq = "";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_pre(int c);
    if (kp < 0) return 1'b0;
    return c >= kp + pdiv && (c - kp - pdiv) % (pdiv + 1) == 0;
  endfunction

  function automatic bit exp_hit(int sel, int c);
    int n;
    if (sel == 7) return is_pre(c);
    if (sel == 6) return ks >= 0 && c >= ks + sdv && (c - ks - sdv) % (sdv + 1) == 0;
    if (kj[sel] < 0 || !is_pre(c)) return 1'b0;
    n = 0;
    for (int t = kj[sel]; t <= c; t++) if (is_pre(t)) n++;
    if (sel < 3) return n % (dj[sel] + 1) == 0;
    return n == dj[sel] + 1;
  endfunction

  always @(posedge clk) begin
    #2;
    if (won) begin
      logic s;
      s = (wsel < 6) ? sec_tick[wsel] : (wsel == 6) ? spi_clk_en : pre_tick;
      if (s) begin
        if (exp_q.size() == 0) chk({wreq, " unexpected tick cycle"}, cyc, -1);
        else chk({wreq, " tick cycle"}, cyc, exp_q.pop_front());
      end
    end
  end

  task automatic run_win(int sel, int len, string req);
    int c0;
    @(negedge clk);
    c0 = cyc;
    exp_q.delete();
    for (int c = c0 + 1; c <= c0 + len; c++) if (exp_hit(sel, c)) exp_q.push_back(c);
    wsel = sel; wreq = req; won = 1;
    repeat (len) @(negedge clk);
    won = 0;
    chk({req, " missing ticks"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic wr(int a, int d, output int k);
    @(negedge clk);
    wr_en = 1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 0;
    k = cyc;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = int'(rdata);
  endtask

  task automatic wait_cyc(int n);
    while (cyc != n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, d, t, n;
    repeat (3) @(negedge clk);
    chk("R6 pre_tick in reset", int'(pre_tick), 0);
    chk("R6 spi_clk_en in reset", int'(spi_clk_en), 0);
    chk("R6 sec_tick in reset", int'(sec_tick), 0);
    chk("R6 irq in reset", int'(irq), 0);
    rst = 0;
    #1 addr = 8;
    #1 chk("R6 pending after reset", int'(rdata), 0);
    rd(0, d); chk("R6 divisor after reset", d, 0);

    run_win(3, 20, "R6 one-shot disarmed");

    wr(0, 3, k); kp = k; pdiv = 3;
    run_win(7, 25, "R1 prescaler");

    wr(1, 5, k); ks = k; sdv = 5;
    run_win(6, 30, "R2 spi divider");

    wr(2, 2, k); kj[0] = k; dj[0] = 2;
    run_win(0, 60, "R4 continuous");

    wr(5, 1, k); kj[3] = k; dj[3] = 1;
    run_win(3, 60, "R5 one-shot single");

    rd(8, d); chk("R7 pending set", (d >> 3) & 1, 1);
    wr(8, 16'h0030, k);
    rd(8, d); chk("R7 write 0 keeps", (d >> 3) & 1, 1);
    wr(8, 16'h0008, k);
    rd(8, d); chk("R7 write 1 clears", (d >> 3) & 1, 0);

    wr(5, 0, k); kj[3] = k; dj[3] = 0;
    run_win(3, 40, "R5 re-arm");

    wr(9, 16'h0010, k);
    wr(8, 16'h003f, k);
    repeat (4) @(negedge clk);
    chk("R9 irq masked", int'(irq), 0);
    wr(6, 0, k);
    repeat (10) @(negedge clk);
    chk("R9 irq raised", int'(irq), 1);
    wr(9, 0, k);
    chk("R9 irq disabled", int'(irq), 0);

    wr(7, 2, k);
    n = 0; t = k;
    while (1) begin
      if (is_pre(t)) begin n++; if (n == 3) break; end
      t++;
    end
    wait_cyc(t);
    wr_en = 1; addr = 8; wdata = 16'h0020;
    @(negedge clk);
    wr_en = 0;
    rd(8, d); chk("R8 set beats clear", (d >> 5) & 1, 1);
    wr(8, 16'h0020, k);
    rd(8, d); chk("R8 later clear", (d >> 5) & 1, 0);

    rd(1, d); chk("R10 spi divisor", d, 5);
    rd(7, d); chk("R10 timer5 divisor", d, 2);
    rd(0, d); chk("R10 prescaler divisor", d, 3);
    rd(15, d); chk("R10 unmapped", d, 0);
    rd(9, d); chk("R10 enable readback", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule